// File: doc/BRIEF.md
# Dual-Channel IDE Card Register Decoder

This block sits between a byte-wide synchronous host register bus and two IDE channels on one expansion card. It turns host addresses into drive-side chip selects and register numbers, so that the host reaches each channel's eight command-block registers and its alternate status/device control register. Neighbouring addresses hold a raw drive-interrupt status bit per channel, a four-bit card identity spread one bit per byte, and a pair of per-channel interrupt-enable latches. Each latch is set by any write to its address and cleared by any read of that address. The data written is ignored.

A select register at offset 0 does two jobs. It gates the whole taskfile window, so that no drive sees an access while the window is closed. It also steers the single DMA request/acknowledge pair to exactly one channel. The card interrupt is the OR, over both channels, of each drive interrupt gated by that channel's enable latch. Side effects are taken once, on the rising edge of a strobe, however long the strobe is held.

Top module: `dual_ide_bridge`

## Requirements
- R1: Any write to 0x2200 (channel 0) or 0x3200 (channel 1) sets that channel's interrupt-enable latch whatever the data. Any read of the same address clears it. If a write and a read start in the same cycle, the write wins.
- R2: `card_irq` is high exactly when some channel has both `drv_irq` high and its enable latch set.
- R3: A read of 0x2290 (channel 0) or 0x3290 (channel 1) returns the raw `drv_irq` of that channel in bit 0 and zeros elsewhere. The enable latch has no effect on this value.
- R4: While the window is open, an access to base + (n << 6), with base 0x2000 for channel 0 and 0x3000 for channel 1 and n from 0 to 7, raises only that channel's `drv_cmd_sel` bit and drives n on `drv_addr`. The access is passed through as `drv_rd`/`drv_wr`, and a read returns `drv_rdata`.
- R5: While the window is open, an access to 0x2380 (channel 0) or 0x3380 (channel 1) raises only that channel's `drv_ctl_sel` bit, drives 6 on `drv_addr`, and never raises `drv_cmd_sel`.
- R6: A read at 0x2280 + 4k, for k from 0 to 3, returns identity bit k in bit 0 and zeros elsewhere. Address 0x2280 carries the least significant bit.
- R7: A write to offset 0 stores the byte in the select register, and a read of offset 0 returns it. Bit 0 of the register picks the DMA channel: `dma_req_out` follows that channel's `dma_req_in`, and `dma_ack_in` reaches only that channel's `dma_ack_out` bit. At most one `dma_ack_out` bit is ever high.
- R8: The window is open only when the select register has bit 2 set. While it is closed, taskfile and control addresses raise no select and no `drv_rd`/`drv_wr`, and reads of them return 0x00. Writing 0 closes the window.
- R9: After reset both enable latches are clear, the select register reads 0x00, and the window is closed.
- R10: A latch or select-register side effect uses the address present when the strobe rises. A strobe held high for many cycles acts once, and moving the address under a held strobe has no effect.
- R11: Reads of undecoded offsets return 0x00 and change neither the latches nor the select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 14 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational, valid while host_rd) |
| card_irq | output | 1 | Gated card interrupt |
| drv_cmd_sel | output | 2 | Per-channel command-block select |
| drv_ctl_sel | output | 2 | Per-channel control-block select |
| drv_addr | output | 3 | Drive register number |
| drv_wr | output | 1 | Drive write strobe |
| drv_rd | output | 1 | Drive read strobe |
| drv_wdata | output | 8 | Data to drives |
| drv_rdata | input | 8 | Data from the selected drive |
| drv_irq | input | 2 | Per-channel drive interrupt |
| dma_req_in | input | 2 | Per-channel DMA request |
| dma_req_out | output | 1 | Request of the routed channel |
| dma_ack_in | input | 1 | Acknowledge from the DMA engine |
| dma_ack_out | output | 2 | Acknowledge steered to the routed channel |

## Verification
A vector table sweeps both channels' taskfile strides, their control addresses, status and identity bytes, the select register, and addresses that sit just off a stride. These tell a correct full-address compare apart from one that drops low bits or mixes up the channels. Directed sequences then try the enable latches with different drive-interrupt pairs, which separates gating per channel from gating on the card as a whole. They also hold strobes across an address change, which separates edge-taken side effects from level-taken ones. Writing both routing values, and a nonzero select value without the window bit, shows whether DMA steering and window gating each follow their own bit.

// File: rtl/dib_pkg.sv
package dib_pkg;
   typedef enum logic [2:0] {
      RG_NONE, RG_SEL, RG_TASK, RG_CTRL, RG_IEN, RG_STAT, RG_ID
   } region_e;

   typedef struct packed {
      region_e    region;
      logic       chan;
      logic [2:0] idx;
   } dec_t;
endpackage

// File: rtl/dib_decode.sv
module dib_decode
   import dib_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int NUM_CH    = 2,
   parameter int CH0_BASE  = 'h2000,
   parameter int CH_SPAN   = 'h1000,
   parameter int STRIDE_SH = 6,
   parameter int INTR_OFF  = 'h200,
   parameter int STAT_OFF  = 'h290,
   parameter int CTRL_OFF  = 'h380,
   parameter int ID_OFF    = 'h280,
   parameter int ID_BITS   = 4,
   parameter int ID_STEP   = 4,
   parameter int SEL_ADDR  = 0,
   parameter int CTRL_IDX  = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   localparam int TF_REGS = 8;

   always_comb begin
      int a;
      int base;
      a = int'(addr);
      dec = '{region: RG_NONE, chan: 1'b0, idx: 3'd0};
      if (a == SEL_ADDR) dec.region = RG_SEL;
      for (int c = 0; c < NUM_CH; c++) begin
         base = CH0_BASE + c * CH_SPAN;
         for (int n = 0; n < TF_REGS; n++) begin
            if (a == base + (n << STRIDE_SH)) begin
               dec.region = RG_TASK;
               dec.chan   = 1'(c);
               dec.idx    = 3'(n);
            end
         end
         if (a == base + CTRL_OFF) begin
            dec.region = RG_CTRL;
            dec.chan   = 1'(c);
            dec.idx    = 3'(CTRL_IDX);
         end
         if (a == base + INTR_OFF) begin
            dec.region = RG_IEN;
            dec.chan   = 1'(c);
         end
         if (a == base + STAT_OFF) begin
            dec.region = RG_STAT;
            dec.chan   = 1'(c);
         end
      end
      for (int k = 0; k < ID_BITS; k++) begin
         if (a == CH0_BASE + ID_OFF + k * ID_STEP) begin
            dec.region = RG_ID;
            dec.idx    = 3'(k);
         end
      end
   end
endmodule

// File: rtl/dib_ien_latch.sv
module dib_ien_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_p,
   input  logic clr_p,
   output logic en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en <= 1'b0;
      else if (set_p) en <= 1'b1;
      else if (clr_p) en <= 1'b0;
   end

   assert_set_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      set_p |=> en);
   assert_clear_on_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_p && !set_p) |=> !en);
   assert_hold_without_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_p && !clr_p) |=> $stable(en));
endmodule

// File: rtl/dib_sel_reg.sv
module dib_sel_reg #(
   parameter int DATA_W    = 8,
   parameter int WIN_BIT   = 2,
   parameter int ROUTE_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_p,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] sel_q,
   output logic              win_open,
   output logic              route
);
   if (WIN_BIT >= DATA_W || ROUTE_BIT >= DATA_W || WIN_BIT == ROUTE_BIT) begin : g_bad_bits
      $error("dib_sel_reg: window and route bits must be distinct and inside DATA_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sel_q <= '0;
      else if (wr_p) sel_q <= wdata;
   end

   assign win_open = (|sel_q) && sel_q[WIN_BIT];
   assign route    = sel_q[ROUTE_BIT];

   assert_sel_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_p |=> (sel_q == $past(wdata)));
   assert_sel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_p |=> $stable(sel_q));
endmodule

// File: rtl/dual_ide_bridge.sv
module dual_ide_bridge
   import dib_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int DATA_W    = 8,
   parameter int NUM_CH    = 2,
   parameter int CH0_BASE  = 'h2000,
   parameter int CH_SPAN   = 'h1000,
   parameter int STRIDE_SH = 6,
   parameter int INTR_OFF  = 'h200,
   parameter int STAT_OFF  = 'h290,
   parameter int CTRL_OFF  = 'h380,
   parameter int ID_OFF    = 'h280,
   parameter int ID_BITS   = 4,
   parameter int ID_STEP   = 4,
   parameter int SEL_ADDR  = 0,
   parameter int WIN_BIT   = 2,
   parameter int ROUTE_BIT = 0,
   parameter int CTRL_IDX  = 6,
   parameter logic [ID_BITS-1:0] CARD_ID = ID_BITS'(6)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              card_irq,
   output logic [NUM_CH-1:0] drv_cmd_sel,
   output logic [NUM_CH-1:0] drv_ctl_sel,
   output logic [2:0]        drv_addr,
   output logic              drv_wr,
   output logic              drv_rd,
   output logic [DATA_W-1:0] drv_wdata,
   input  logic [DATA_W-1:0] drv_rdata,
   input  logic [NUM_CH-1:0] drv_irq,
   input  logic [NUM_CH-1:0] dma_req_in,
   output logic              dma_req_out,
   input  logic              dma_ack_in,
   output logic [NUM_CH-1:0] dma_ack_out
);
   localparam int TF_TOP = 7 << STRIDE_SH;

   if (NUM_CH != 2) begin : g_bad_ch
      $error("dual_ide_bridge: exactly two channels are supported");
   end
   if (TF_TOP >= INTR_OFF || TF_TOP >= ID_OFF || CH0_BASE + CH_SPAN + CTRL_OFF >= (1 << ADDR_W)) begin : g_bad_map
      $error("dual_ide_bridge: address map overlaps or exceeds ADDR_W");
   end
   if (ID_BITS > 8 || CTRL_IDX > 7) begin : g_bad_id
      $error("dual_ide_bridge: ID_BITS must be at most 8 and CTRL_IDX at most 7");
   end

   // strobe edge detection: side effects only on the rising edge
   logic rd_q, wr_q, rd_p, wr_p;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         wr_q <= 1'b0;
      end else begin
         rd_q <= host_rd;
         wr_q <= host_wr;
      end
   end
   assign rd_p = host_rd && !rd_q;
   assign wr_p = host_wr && !wr_q;

   dec_t dec;
   dib_decode #(
      .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH0_BASE(CH0_BASE), .CH_SPAN(CH_SPAN),
      .STRIDE_SH(STRIDE_SH), .INTR_OFF(INTR_OFF), .STAT_OFF(STAT_OFF),
      .CTRL_OFF(CTRL_OFF), .ID_OFF(ID_OFF), .ID_BITS(ID_BITS), .ID_STEP(ID_STEP),
      .SEL_ADDR(SEL_ADDR), .CTRL_IDX(CTRL_IDX)
   ) u_dec (
      .addr(host_addr),
      .dec (dec)
   );

   logic [DATA_W-1:0] sel_q;
   logic              win_open, route;
   dib_sel_reg #(.DATA_W(DATA_W), .WIN_BIT(WIN_BIT), .ROUTE_BIT(ROUTE_BIT)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_p    (wr_p && dec.region == RG_SEL),
      .wdata   (host_wdata),
      .sel_q   (sel_q),
      .win_open(win_open),
      .route   (route)
   );

   logic [NUM_CH-1:0] ien;
   logic              tf_ok;
   assign tf_ok = (host_rd || host_wr) && win_open;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dib_ien_latch u_ien (
         .clk  (clk),
         .rst_n(rst_n),
         .set_p(wr_p && dec.region == RG_IEN && dec.chan == 1'(c)),
         .clr_p(rd_p && dec.region == RG_IEN && dec.chan == 1'(c)),
         .en   (ien[c])
      );
      assign drv_cmd_sel[c] = tf_ok && dec.region == RG_TASK && dec.chan == 1'(c);
      assign drv_ctl_sel[c] = tf_ok && dec.region == RG_CTRL && dec.chan == 1'(c);
      assign dma_ack_out[c] = dma_ack_in && route == 1'(c);
   end

   logic any_sel;
   assign any_sel   = |{drv_cmd_sel, drv_ctl_sel};
   assign drv_addr  = any_sel ? dec.idx : 3'd0;
   assign drv_rd    = host_rd && any_sel;
   assign drv_wr    = host_wr && any_sel;
   assign drv_wdata = host_wdata;

   assign card_irq    = |(drv_irq & ien);
   assign dma_req_out = dma_req_in[route];

   logic [7:0] id_ext;
   assign id_ext = 8'(CARD_ID);

   always_comb begin
      host_rdata = '0;
      if (host_rd) begin
         unique case (dec.region)
            RG_SEL:  host_rdata = sel_q;
            RG_TASK,
            RG_CTRL: host_rdata = win_open ? drv_rdata : '0;
            RG_STAT: host_rdata = DATA_W'(drv_irq[dec.chan]);
            RG_ID:   host_rdata = DATA_W'(id_ext[dec.idx]);
            default: host_rdata = '0;
         endcase
      end
   end

   assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({drv_cmd_sel, drv_ctl_sel}));
   assert_closed_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !win_open |-> (!drv_rd && !drv_wr && !(|drv_cmd_sel) && !(|drv_ctl_sel)));
   assert_single_dma_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dma_ack_out));
   assert_irq_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|ien) || !(|drv_irq)) |-> !card_irq);
   assert_undecoded_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && dec.region == RG_NONE) |-> (host_rdata == '0));
endmodule

// File: tb/dual_ide_bridge_bench.sv
module dual_ide_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] host_addr = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_wdata = '0, host_rdata;
   logic        card_irq;
   logic [1:0]  drv_cmd_sel, drv_ctl_sel;
   logic [2:0]  drv_addr;
   logic        drv_wr, drv_rd;
   logic [7:0]  drv_wdata;
   logic [7:0]  drv_rdata = 8'h5A;
   logic [1:0]  drv_irq = 2'b00;
   logic [1:0]  dma_req_in = 2'b00;
   logic        dma_req_out;
   logic        dma_ack_in = 1'b0;
   logic [1:0]  dma_ack_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dual_ide_bridge #(.CARD_ID(4'b1101)) u_dual_ide_bridge (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .card_irq(card_irq), .drv_cmd_sel(drv_cmd_sel), .drv_ctl_sel(drv_ctl_sel),
      .drv_addr(drv_addr), .drv_wr(drv_wr), .drv_rd(drv_rd), .drv_wdata(drv_wdata),
      .drv_rdata(drv_rdata), .drv_irq(drv_irq), .dma_req_in(dma_req_in),
      .dma_req_out(dma_req_out), .dma_ack_in(dma_ack_in), .dma_ack_out(dma_ack_out)
   );

   // row: addr[31:16] cmd_sel[15:14] ctl_sel[13:12] drv_addr[11:9] rdata[8:1] pad[0]
   localparam int NV = 20;
   localparam logic [31:0] VEC [0:NV-1] = '{
      {16'h2000, 2'b01, 2'b00, 3'd0, 8'h5A, 1'b0},
      {16'h2040, 2'b01, 2'b00, 3'd1, 8'h5A, 1'b0},
      {16'h20C0, 2'b01, 2'b00, 3'd3, 8'h5A, 1'b0},
      {16'h21C0, 2'b01, 2'b00, 3'd7, 8'h5A, 1'b0},
      {16'h3000, 2'b10, 2'b00, 3'd0, 8'h5A, 1'b0},
      {16'h3140, 2'b10, 2'b00, 3'd5, 8'h5A, 1'b0},
      {16'h31C0, 2'b10, 2'b00, 3'd7, 8'h5A, 1'b0},
      {16'h2380, 2'b00, 2'b01, 3'd6, 8'h5A, 1'b0},
      {16'h3380, 2'b00, 2'b10, 3'd6, 8'h5A, 1'b0},
      {16'h2010, 2'b00, 2'b00, 3'd0, 8'h00, 1'b0},
      {16'h2004, 2'b00, 2'b00, 3'd0, 8'h00, 1'b0},
      {16'h1000, 2'b00, 2'b00, 3'd0, 8'h00, 1'b0},
      {16'h2290, 2'b00, 2'b00, 3'd0, 8'h00, 1'b0},
      {16'h3290, 2'b00, 2'b00, 3'd0, 8'h01, 1'b0},
      {16'h2280, 2'b00, 2'b00, 3'd0, 8'h01, 1'b0},
      {16'h2284, 2'b00, 2'b00, 3'd0, 8'h00, 1'b0},
      {16'h2288, 2'b00, 2'b00, 3'd0, 8'h01, 1'b0},
      {16'h228C, 2'b00, 2'b00, 3'd0, 8'h01, 1'b0},
      {16'h0000, 2'b00, 2'b00, 3'd0, 8'h04, 1'b0},
      {16'h2200, 2'b00, 2'b00, 3'd0, 8'h00, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [13:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   // read: samples data and drive-side selects while the strobe is high
   logic [7:0] r_data;
   logic [1:0] r_cmd, r_ctl;
   logic [2:0] r_da;
   logic       r_drd;
   task automatic bus_read(input logic [13:0] a);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #2;
      r_data = host_rdata; r_cmd = drv_cmd_sel; r_ctl = drv_ctl_sel;
      r_da = drv_addr; r_drd = drv_rd;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state
      drv_irq = 2'b11;
      #1 check("R9 card_irq after reset", card_irq, 0);
      bus_read(14'h0000);
      check("R9 select reads zero", r_data, 8'h00);
      bus_read(14'h2000);
      check("R9 window closed cmd_sel", r_cmd, 2'b00);
      check("R9 window closed rdata", r_data, 8'h00);

      // table sweep with window open, route channel 0
      drv_irq = 2'b10;
      bus_write(14'h0000, 8'h04);
      for (int i = 0; i < NV; i++) begin
         bus_read(VEC[i][29:16]);
         check($sformatf("R3 R4 R5 R6 R7 R11 row %0d rdata", i), r_data, VEC[i][8:1]);
         check($sformatf("R4 R5 row %0d selects", i), {r_cmd, r_ctl}, VEC[i][15:12]);
         check($sformatf("R4 R5 row %0d drv_addr", i), r_da, VEC[i][11:9]);
         check($sformatf("R4 R8 row %0d drv_rd", i), r_drd, |VEC[i][15:12]);
      end

      // R1 and R2: latch set/clear and gating
      drv_irq = 2'b11;
      #1 check("R2 no enable no irq", card_irq, 0);
      bus_write(14'h2200, 8'h00);
      #1 check("R1 write sets ch0 enable", card_irq, 1);
      drv_irq = 2'b10;
      #1 check("R2 ch1 irq not enabled", card_irq, 0);
      drv_irq = 2'b01;
      #1 check("R2 ch0 irq enabled", card_irq, 1);
      bus_read(14'h2200);
      check("R1 read returns zero", r_data, 8'h00);
      #1 check("R1 read clears ch0 enable", card_irq, 0);
      bus_write(14'h3200, 8'hFF);
      drv_irq = 2'b10;
      #1 check("R1 write sets ch1 enable", card_irq, 1);
      bus_read(14'h3290);
      check("R3 status raw ch1", r_data, 8'h01);
      bus_read(14'h3200);
      #1 check("R1 read clears ch1 enable", card_irq, 0);

      // R10: held strobe with address moved underneath
      drv_irq = 2'b01;
      @(negedge clk);
      host_addr = 14'h1000; host_wr = 1'b1;
      @(negedge clk);
      host_addr = 14'h2200;
      repeat (2) @(negedge clk);
      host_wr = 1'b0;
      #1 check("R10 held write no set", card_irq, 0);
      bus_write(14'h2200, 8'h00);
      @(negedge clk);
      host_addr = 14'h1000; host_rd = 1'b1;
      @(negedge clk);
      host_addr = 14'h2200;
      repeat (3) @(negedge clk);
      host_rd = 1'b0;
      #1 check("R10 held read no clear", card_irq, 1);

      // R11: undecoded read has no side effect
      bus_read(14'h1234);
      check("R11 undecoded reads zero", r_data, 8'h00);
      #1 check("R11 enable kept", card_irq, 1);
      bus_read(14'h0000);
      check("R11 select kept", r_data, 8'h04);

      // R7: DMA routing
      dma_ack_in = 1'b1;
      dma_req_in = 2'b01;
      #1 check("R7 req from ch0", dma_req_out, 1);
      check("R7 ack to ch0", dma_ack_out, 2'b01);
      bus_write(14'h0000, 8'h05);
      dma_req_in = 2'b01;
      #1 check("R7 ch0 req ignored on ch1 route", dma_req_out, 0);
      dma_req_in = 2'b10;
      #1 check("R7 req from ch1", dma_req_out, 1);
      check("R7 ack to ch1", dma_ack_out, 2'b10);
      bus_read(14'h3000);
      check("R7 window still open", r_cmd, 2'b10);

      // R8: window closing
      bus_write(14'h0000, 8'h00);
      bus_read(14'h3000);
      check("R8 zero closes cmd_sel", r_cmd, 2'b00);
      check("R8 zero closes drv_rd", r_drd, 0);
      check("R8 zero closes rdata", r_data, 8'h00);
      bus_write(14'h0000, 8'h01);
      bus_read(14'h2380);
      check("R8 nonzero without window bit", r_ctl, 2'b00);
      @(negedge clk);
      host_addr = 14'h2040; host_wdata = 8'h33; host_wr = 1'b1;
      #2 check("R8 closed no drv_wr", drv_wr, 0);
      @(negedge clk);
      host_wr = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule